// File: doc/BRIEF.md
# CPU Low-Power and Break Controller

This controller sits next to a small 8-bit CPU core and decides when the core's clock runs. It also decides when the interrupt-mask (I) bit of the condition codes is written, and when a debug break takes over the instruction stream.

When the decoder reports a wait or stop instruction, the controller clears the mask bit and gates the CPU clock. Wait mode ends on any interrupt request. Stop mode ends only on an external request. It then holds the clock off for a programmable oscillator settling period, which an oscillator-ready input can cut short. Reset returns the block to normal running from any state and forces the mask bit to one.

A break-address match makes the controller inject the software-interrupt opcode into the instruction register. In the same cycle it presents a 16-bit vector address with a one-cycle load strobe, so the program counter captures the vector on the next clock edge. The vector depends on whether monitor mode is selected. All pins are plain control and status levels or strobes. There is no data stream, so there is no valid/ready handshake and no back-pressure: every strobe is acted on in the cycle it is high.

Top module: `lpbrk_ctrl`

## Requirements
- R1: While `rst_n` is low, `ibit_we` and `ibit_val` are both 1, `cpu_clk_en` is 1 and no break strobe is issued, even when interrupt requests are high in the same cycle. After reset the block runs normally.
- R2: In normal running with no break match, `dec_wait` or `dec_stop` drives `ibit_we`=1 and `ibit_val`=0 in that cycle, and `cpu_clk_en` is 0 from the next cycle on.
- R3: In wait mode, `irq_int` or `irq_ext` makes `cpu_clk_en` return to 1 in the next cycle, and `ibit_we` stays 0, so the mask stays clear.
- R4: In stop mode, `irq_int` has no effect and `cpu_clk_en` stays 0. Only `irq_ext` ends stop mode.
- R5: After the `irq_ext` that ends stop mode, `cpu_clk_en` stays 0 for exactly `STAB_CYCLES` cycles, then returns to 1. If `osc_ready` is high during the settling period, `cpu_clk_en` is 1 from the next cycle.
- R6: In normal running, `brk_match` together with `last_cycle` raises `swi_force` and `pc_load` in that same cycle.
- R7: `brk_match` without `last_cycle` raises no strobe. The break stays pending until a cycle with `instr_end` high, and the strobes are raised in that cycle.
- R8: While `pc_load` is high, `pc_vec` is 16'hFFFC when `mon_mode` is 0 and 16'hFEFC when `mon_mode` is 1.
- R9: `swi_force` and `pc_load` last one cycle. While the break is active, a further `brk_match` with `last_cycle` raises no strobe.
- R10: Inside the break, `dec_rti` returns to normal running only if `brk_match` is low in that cycle. Otherwise the break stays active.
- R11: `dec_wait` and `dec_stop` have no effect outside normal running: there is no mask write and the clock stays as it was. In normal running a break match takes priority over them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_wait | input | 1 | Decoder strobe: wait instruction |
| dec_stop | input | 1 | Decoder strobe: stop instruction |
| dec_rti | input | 1 | Decoder strobe: return from interrupt |
| instr_end | input | 1 | Current instruction completes in this cycle |
| last_cycle | input | 1 | This cycle is the last cycle of the current instruction |
| brk_match | input | 1 | Break address comparator match |
| irq_int | input | 1 | Internal interrupt request |
| irq_ext | input | 1 | External interrupt request |
| mon_mode | input | 1 | Monitor mode selected |
| osc_ready | input | 1 | Oscillator reports it is stable |
| cpu_clk_en | output | 1 | CPU clock enable |
| ibit_we | output | 1 | Write enable for the I bit |
| ibit_val | output | 1 | Value to write into the I bit |
| swi_force | output | 1 | Load the SWI opcode into the instruction register |
| pc_load | output | 1 | Program counter captures `pc_vec` at the next edge |
| pc_vec | output | 16 | Break vector address |

## Verification
A wrong state register shows up first on `cpu_clk_en`, in the cycle right after the faulty transition. Examples are a clock that stays gated after a wake-up, or one that runs during stop or settling. Wrong break state shows as a missing, early or repeated `swi_force`/`pc_load` pulse in the cycle the entry condition is or is not met. A settling counter that is off by one moves the rising edge of `cpu_clk_en` by a cycle. The bench therefore compares every output in every cycle against a reference model.

// File: rtl/lpbrk_pkg.sv
package lpbrk_pkg;
  typedef enum logic [5:0] {
    ST_RUN  = 6'b000001,
    ST_WAIT = 6'b000010,
    ST_STOP = 6'b000100,
    ST_STAB = 6'b001000,
    ST_PEND = 6'b010000,
    ST_BRK  = 6'b100000
  } lp_state_e;

  localparam logic [15:0] VEC_NORMAL  = 16'hFFFC;
  localparam logic [15:0] VEC_MONITOR = 16'hFEFC;
endpackage

// File: rtl/lpbrk_stab_timer.sv
module lpbrk_stab_timer #(
  parameter int STAB_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic osc_ready,
  output logic done
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign done = run && (osc_ready || cnt_q == LAST);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !done |=> cnt_q <= LAST);
endmodule

// File: rtl/lpbrk_fsm.sv
module lpbrk_fsm
  import lpbrk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dec_wait,
  input  logic      dec_stop,
  input  logic      dec_rti,
  input  logic      instr_end,
  input  logic      last_cycle,
  input  logic      brk_match,
  input  logic      irq_int,
  input  logic      irq_ext,
  input  logic      stab_done,
  output lp_state_e st_q,
  output logic      entry,
  output logic      mask_clr
);
  lp_state_e nxt;

  always_comb begin
    nxt      = st_q;
    entry    = 1'b0;
    mask_clr = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (brk_match) begin
          if (last_cycle) begin
            nxt   = ST_BRK;
            entry = 1'b1;
          end else begin
            nxt = ST_PEND;
          end
        end else if (dec_wait) begin
          nxt      = ST_WAIT;
          mask_clr = 1'b1;
        end else if (dec_stop) begin
          nxt      = ST_STOP;
          mask_clr = 1'b1;
        end
      end
      ST_WAIT: if (irq_int || irq_ext) nxt = ST_RUN;
      ST_STOP: if (irq_ext) nxt = ST_STAB;
      ST_STAB: if (stab_done) nxt = ST_RUN;
      ST_PEND: begin
        if (instr_end) begin
          nxt   = ST_BRK;
          entry = 1'b1;
        end
      end
      ST_BRK:  if (dec_rti && !brk_match) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= nxt;
  end

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_q) == 1);
  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_STOP && !irq_ext |=> st_q == ST_STOP);
  // R10
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_BRK && brk_match |=> st_q == ST_BRK);
endmodule

// File: rtl/lpbrk_vec_gen.sv
module lpbrk_vec_gen
  import lpbrk_pkg::*;
(
  input  logic        entry,
  input  logic        mon_mode,
  output logic        swi_force,
  output logic        pc_load,
  output logic [15:0] pc_vec
);
  assign swi_force = entry;
  assign pc_load   = entry;
  assign pc_vec    = mon_mode ? VEC_MONITOR : VEC_NORMAL;
endmodule

// File: rtl/lpbrk_ctrl.sv
module lpbrk_ctrl
  import lpbrk_pkg::*;
#(
  parameter int STAB_CYCLES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec_wait,
  input  logic        dec_stop,
  input  logic        dec_rti,
  input  logic        instr_end,
  input  logic        last_cycle,
  input  logic        brk_match,
  input  logic        irq_int,
  input  logic        irq_ext,
  input  logic        mon_mode,
  input  logic        osc_ready,
  output logic        cpu_clk_en,
  output logic        ibit_we,
  output logic        ibit_val,
  output logic        swi_force,
  output logic        pc_load,
  output logic [15:0] pc_vec
);
  lp_state_e st;
  logic      entry, mask_clr, stab_done;

  lpbrk_fsm fsm_i (
    .clk, .rst_n, .dec_wait, .dec_stop, .dec_rti, .instr_end, .last_cycle,
    .brk_match, .irq_int, .irq_ext, .stab_done,
    .st_q(st), .entry, .mask_clr
  );

  lpbrk_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) tmr_i (
    .clk, .rst_n, .run(st == ST_STAB), .osc_ready, .done(stab_done)
  );

  logic entry_q;
  always_comb entry_q = entry && rst_n;

  lpbrk_vec_gen vec_i (
    .entry(entry_q), .mon_mode, .swi_force, .pc_load, .pc_vec
  );

  assign cpu_clk_en = (st == ST_RUN) || (st == ST_PEND) || (st == ST_BRK) || !rst_n;
  assign ibit_we    = !rst_n || mask_clr;
  assign ibit_val   = !rst_n;

  // R2
  clk_gate_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> $past(ibit_we && !ibit_val));
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_force |=> !swi_force);
  // R7
  load_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> cpu_clk_en && swi_force);
endmodule

// File: tb/lpbrk_ctrl_tb.sv
module lpbrk_ctrl_tb_top;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_wait, dec_stop, dec_rti, instr_end, last_cycle, brk_match;
  logic irq_int, irq_ext, mon_mode, osc_ready;
  logic cpu_clk_en, ibit_we, ibit_val, swi_force, pc_load;
  logic [15:0] pc_vec;

  always #10 clk = ~clk;

  lpbrk_ctrl #(.STAB_CYCLES(N)) dut_i (
    .clk, .rst_n, .dec_wait, .dec_stop, .dec_rti, .instr_end, .last_cycle,
    .brk_match, .irq_int, .irq_ext, .mon_mode, .osc_ready,
    .cpu_clk_en, .ibit_we, .ibit_val, .swi_force, .pc_load, .pc_vec
  );

  int n_cmp = 0, n_bad = 0;
  // model: 0 run, 1 wait, 2 stop, 3 settle, 4 pending, 5 break
  int m_st = 0, m_cnt = 0, m_nxt = 0, m_ncnt = 0;
  logic r_rst, r_dw, r_ds, r_rti, r_end, r_last, r_brk, r_ii, r_ie, r_mon, r_osc;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_clk(int s);
    return s == 0 || s == 4 || s == 5;
  endfunction

  function automatic bit m_entry(int s);
    return (s == 0 && r_brk && r_last) || (s == 4 && r_end);
  endfunction

  function automatic int m_next(int s, int c);
    case (s)
      0: return r_brk ? (r_last ? 5 : 4) : r_dw ? 1 : r_ds ? 2 : 0;
      1: return (r_ii || r_ie) ? 0 : 1;
      2: return r_ie ? 3 : 2;
      3: return (r_osc || c == N - 1) ? 0 : 3;
      4: return r_end ? 5 : 4;
      default: return (r_rti && !r_brk) ? 0 : 5;
    endcase
  endfunction

  task automatic clr();
    {r_dw, r_ds, r_rti, r_end, r_last, r_brk, r_ii, r_ie, r_mon, r_osc} = '0;
    r_rst = 1'b1;
  endtask

  // apply inputs at negedge, compare against the model
  task automatic settle();
    bit e, we;
    string t;
    @(negedge clk);
    rst_n = r_rst; dec_wait = r_dw; dec_stop = r_ds; dec_rti = r_rti;
    instr_end = r_end; last_cycle = r_last; brk_match = r_brk;
    irq_int = r_ii; irq_ext = r_ie; mon_mode = r_mon; osc_ready = r_osc;
    #2;
    if (!r_rst) begin
      chk("R1 clk_en", 16'(cpu_clk_en), 16'd1);
      chk("R1 ibit_we", 16'(ibit_we), 16'd1);
      chk("R1 ibit_val", 16'(ibit_val), 16'd1);
      chk("R1 swi_force", 16'(swi_force), 16'd0);
      m_nxt = 0; m_ncnt = 0;
    end else begin
      t = (m_st == 1) ? "R3" : (m_st == 2) ? "R4" : (m_st == 3) ? "R5" : "R2";
      chk({t, " clk_en"}, 16'(cpu_clk_en), 16'(m_clk(m_st)));
      e = m_entry(m_st);
      chk(m_st == 4 ? "R7 swi_force" : "R6 swi_force", 16'(swi_force), 16'(e));
      chk("R9 pc_load", 16'(pc_load), 16'(e));
      if (e) chk("R8 pc_vec", pc_vec, r_mon ? 16'hFEFC : 16'hFFFC);
      we = m_st == 0 && !r_brk && (r_dw || r_ds);
      chk("R11 ibit_we", 16'(ibit_we), 16'(we));
      if (we) chk("R2 ibit_val", 16'(ibit_val), 16'd0);
      m_nxt  = m_next(m_st, m_cnt);
      m_ncnt = (m_st == 3) ? m_cnt + 1 : 0;
    end
  endtask

  task automatic advance();
    @(posedge clk); #1;
    m_st = m_nxt; m_cnt = m_ncnt;
  endtask

  task automatic step();
    settle(); advance();
  endtask

  // one random draw per cycle with fixed weights
  task automatic rnd();
    r_rst  = ($urandom % 400) != 0;
    r_dw   = ($urandom % 10) == 0;
    r_ds   = ($urandom % 10) == 0;
    r_rti  = ($urandom % 4) == 0;
    r_end  = ($urandom % 3) == 0;
    r_last = ($urandom % 3) == 0;
    r_brk  = ($urandom % 12) == 0;
    r_ii   = ($urandom % 8) == 0;
    r_ie   = ($urandom % 10) == 0;
    r_mon  = ($urandom % 2) == 0;
    r_osc  = ($urandom % 40) == 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int n;
    void'($urandom(32'd1234));
    clr(); r_rst = 1'b0; r_ii = 1'b1; r_ie = 1'b1;
    rst_n = 1'b0;
    step(); step();                         // R1 reset beats interrupts
    clr(); step();

    r_dw = 1'b1; settle();                  // R2
    chk("R2 we on wait", 16'(ibit_we), 16'd1);
    advance(); clr(); settle();
    chk("R2 clock gated", 16'(cpu_clk_en), 16'd0);
    r_ds = 1'b1; r_dw = 1'b1;               // R11 ignored in wait
    settle(); chk("R11 no write in wait", 16'(ibit_we), 16'd0); advance();
    clr(); r_ii = 1'b1; settle();           // R3
    chk("R3 no mask write on exit", 16'(ibit_we), 16'd0);
    advance(); clr(); settle();
    chk("R3 clock back", 16'(cpu_clk_en), 16'd1); advance();

    r_ds = 1'b1; step(); clr();             // R4
    r_ii = 1'b1; step(); step(); settle();
    chk("R4 internal irq ignored", 16'(cpu_clk_en), 16'd0); advance();
    clr(); r_ie = 1'b1; step(); clr();      // R5 full count
    n = 0;
    for (int k = 0; k < N + 10; k++) begin
      settle();
      if (cpu_clk_en) break;
      n++; advance();
    end
    chk("R5 settle length", 16'(n), 16'(N));
    advance();

    r_ds = 1'b1; step(); clr(); r_ie = 1'b1; step(); clr();
    step(); step(); r_osc = 1'b1; step(); clr(); settle();
    chk("R5 osc_ready cut", 16'(cpu_clk_en), 16'd1); advance();

    r_brk = 1'b1; r_last = 1'b1; r_dw = 1'b1; settle();   // R6 R11
    chk("R6 immediate swi", 16'(swi_force), 16'd1);
    chk("R8 normal vector", pc_vec, 16'hFFFC);
    chk("R11 break beats wait", 16'(ibit_we), 16'd0);
    advance(); settle();
    chk("R9 no re-entry", 16'(swi_force), 16'd0); advance();
    clr(); r_rti = 1'b1; r_brk = 1'b1; step();             // R10
    clr(); r_dw = 1'b1; step(); clr(); settle();
    chk("R10 still in break", 16'(cpu_clk_en), 16'd1); advance();
    r_rti = 1'b1; step(); clr(); r_dw = 1'b1; step(); clr(); settle();
    chk("R10 returned", 16'(cpu_clk_en), 16'd0); advance();
    r_ie = 1'b1; step(); clr();

    r_brk = 1'b1; settle();                 // R7
    chk("R7 no strobe mid-instr", 16'(swi_force), 16'd0); advance();
    clr(); step(); r_end = 1'b1; r_mon = 1'b1; settle();
    chk("R7 strobe at end", 16'(pc_load), 16'd1);
    chk("R8 monitor vector", pc_vec, 16'hFEFC); advance();
    clr(); r_rti = 1'b1; step();

    clr(); r_dw = 1'b1; step(); clr(); r_rst = 1'b0; settle();   // R1
    chk("R1 reset in wait", 16'(cpu_clk_en), 16'd1); advance();
    clr(); step();

    for (int k = 0; k < 6000; k++) begin
      rnd(); step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule